// File: doc/BRIEF.md
# MII Management Bus Master

This block is a register-driven master for the two-wire PHY management bus. A host writes a small set of registers to issue single register writes, single register reads, or a repeating scan of one PHY register. The block produces the management clock by dividing the system clock. It drives or samples the shared data line through separate out, output-enable and in signals, and an external pad joins these into one tri-state wire.

A write frame starts as soon as the host stores a value into the write-data register. A read frame starts when the host sets the read bit of the command register. While a read is in flight, a not-valid flag is raised alongside busy. In scan mode the master repeats reads of the selected register back to back, and it updates a link-fail flag from the link bit of every result. A bit in the configuration register holds the whole management engine in reset for as long as it stays set.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the indicator and read-data registers read 0, mdc is low and mdio_oe is low.
- R2: The address register (select 2) holds the PHY address in bits 12:8 and the register address in bits 4:0, and it reads back with all other bits zero. These two fields are sent in every frame, MSB first.
- R3: A write to the write-data register (select 3) while idle sends one 64-bit frame with mdio_oe high for all 64 bits. The frame is 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits, MSB first.
- R4: Writing the command register (select 1) with bit 0 set while idle sends a read frame. The frame is 32 ones, 01, opcode 10, PHY address, register address, and mdio_oe is low from bit 46 onward. The 16 bits sampled in bits 48 to 63, MSB first, appear in the read-data register (select 4).
- R5: In the indicator register (select 5), busy (bit 0) is set on the clock edge that accepts a start and clears after the frame ends. Not-valid (bit 2) is set when a read is issued and clears when its data is stored.
- R6: With command bit 1 set, reads of the selected register repeat with busy held high. Link-fail (indicator bit 3) becomes the inverse of bit 2 of each result. After bit 1 is cleared, the current frame completes and then no further frames start.
- R7: While configuration bit 15 (select 0) is set, any frame in progress is abandoned, busy, not-valid and link-fail read 0, mdc and mdio_oe stay low, and new starts are ignored.
- R8: The mdc period is MDC_DIV system clocks with a high phase of MDC_DIV/2. mdio_o changes only when mdc falls, and mdio_i is sampled when mdc rises.
- R9: While busy, writes to the write-data register and read commands neither start a frame nor alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 cfg, 1 cmd, 2 addr, 3 wdata, 4 rdata, 5 indicator) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A wrong bit counter or shift register shows up as a misplaced opcode, address or turnaround bit in the captured frame, or as an output enable that drops at the wrong bit. Either fault is visible within the 64 mdc periods of one frame. A divider fault shows at the first mdc edge as a wrong period or duty. A stuck busy, not-valid or link-fail flag shows on the indicator register one system clock after the frame ends, and a scan that fails to stop shows as extra mdc edges after busy drops.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int FRAME_BITS = 64;
   localparam int TA_FIRST   = 46;
   localparam int DATA_FIRST = 48;

   typedef enum logic [2:0] {
      SEL_CFG = 3'd0,
      SEL_CMD = 3'd1,
      SEL_ADR = 3'd2,
      SEL_WDT = 3'd3,
      SEL_RDT = 3'd4,
      SEL_IND = 3'd5
   } reg_sel_e;

   localparam int CFG_RST_BIT = 15;
   localparam int CMD_RD_BIT  = 0;
   localparam int CMD_SCN_BIT = 1;
   localparam int LINK_BIT    = 2;

   function automatic logic [FRAME_BITS-1:0] mk_frame(input logic rd,
                                                      input logic [4:0] phy,
                                                      input logic [4:0] ra,
                                                      input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
              (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
   endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic fall
);
   localparam int CW   = $clog2(DIV);
   localparam int HALF = DIV / 2;

   logic [CW-1:0] cnt;

   assign rise = run && (cnt == CW'(HALF - 1));
   assign fall = run && (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= fall ? '0 : cnt + 1'b1;
         if (rise)
            mdc <= 1'b1;
         else if (fall)
            mdc <= 1'b0;
      end
   end
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= '1;
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++)
                  ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_mgmt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        start,
   input  logic        rd_op,
   input  logic [4:0]  phy,
   input  logic [4:0]  ra,
   input  logic [15:0] wd,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdi,
   output logic        active,
   output logic        mdo,
   output logic        mdoe,
   output logic        done,
   output logic [15:0] rd_word
);
   localparam int IW = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] sh;
   logic [IW-1:0]         idx;
   logic                  rd_q;
   logic [15:0]           rsh;

   assign mdo     = active & sh[FRAME_BITS-1];
   assign mdoe    = active & ~(rd_q & (idx >= IW'(TA_FIRST)));
   assign rd_word = rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         idx    <= '0;
         rd_q   <= 1'b0;
         rsh    <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else if (clr) begin
         sh     <= '0;
         idx    <= '0;
         rd_q   <= 1'b0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            sh     <= mk_frame(rd_op, phy, ra, wd);
            idx    <= '0;
            rd_q   <= rd_op;
            active <= 1'b1;
         end else if (active) begin
            if (rise && rd_q && (idx >= IW'(DATA_FIRST)))
               rsh <= {rsh[14:0], mdi};
            if (fall) begin
               if (idx == IW'(FRAME_BITS - 1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
                  sh  <= {sh[FRAME_BITS-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int MDC_DIV     = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_sel,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (MDC_DIV < 4 || (MDC_DIV % 2) != 0) begin : g_bad_div
         $error("MDC_DIV must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > MDC_DIV / 2 - 1) begin : g_bad_sync
         $error("SYNC_STAGES must fit inside half an mdc period");
      end
   endgenerate

   logic [15:0] cfg_q;
   logic [1:0]  cmd_q;
   logic [4:0]  phy_q, ra_q;
   logic [15:0] wdat_q, rdat_q;
   logic        busy_q, nval_q, lfail_q;
   logic        rd_frame_q, scan_frame_q;

   logic        mgmt_rst;
   logic        wr_cfg, wr_cmd, wr_adr, wr_wdt;
   logic        start_wr, start_rd, restart, eng_start, eng_rd;
   logic        eng_active, eng_done, eng_mdo, eng_mdoe;
   logic [15:0] eng_word;
   logic        rise, fall, mdi_s;

   assign mgmt_rst = cfg_q[CFG_RST_BIT];
   assign wr_cfg   = reg_wr && (reg_sel == SEL_CFG);
   assign wr_cmd   = reg_wr && (reg_sel == SEL_CMD);
   assign wr_adr   = reg_wr && (reg_sel == SEL_ADR);
   assign wr_wdt   = reg_wr && (reg_sel == SEL_WDT);

   assign start_wr  = wr_wdt && !busy_q && !mgmt_rst;
   assign start_rd  = wr_cmd && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_SCN_BIT])
                      && !busy_q && !mgmt_rst;
   assign restart   = eng_done && cmd_q[CMD_SCN_BIT] && !mgmt_rst;
   assign eng_start = start_wr || start_rd || restart;
   assign eng_rd    = !start_wr;

   mdio_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (eng_active && !mgmt_rst),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (mdio_i),
      .q    (mdi_s)
   );

   mdio_frame_eng u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mgmt_rst),
      .start  (eng_start),
      .rd_op  (eng_rd),
      .phy    (phy_q),
      .ra     (ra_q),
      .wd     (start_wr ? reg_wdata : wdat_q),
      .rise   (rise),
      .fall   (fall),
      .mdi    (mdi_s),
      .active (eng_active),
      .mdo    (eng_mdo),
      .mdoe   (eng_mdoe),
      .done   (eng_done),
      .rd_word(eng_word)
   );

   assign mdio_o  = eng_mdo;
   assign mdio_oe = eng_mdoe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         phy_q <= '0;
         ra_q  <= '0;
      end else begin
         if (wr_cfg)
            cfg_q <= reg_wdata;
         if (wr_adr) begin
            phy_q <= reg_wdata[12:8];
            ra_q  <= reg_wdata[4:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q        <= '0;
         wdat_q       <= '0;
         rdat_q       <= '0;
         busy_q       <= 1'b0;
         nval_q       <= 1'b0;
         lfail_q      <= 1'b0;
         rd_frame_q   <= 1'b0;
         scan_frame_q <= 1'b0;
      end else if (mgmt_rst) begin
         cmd_q        <= '0;
         busy_q       <= 1'b0;
         nval_q       <= 1'b0;
         lfail_q      <= 1'b0;
         rd_frame_q   <= 1'b0;
         scan_frame_q <= 1'b0;
      end else begin
         if (wr_cmd)
            cmd_q <= reg_wdata[1:0];
         if (start_wr)
            wdat_q <= reg_wdata;
         if (eng_done && rd_frame_q) begin
            rdat_q <= eng_word;
            nval_q <= 1'b0;
            if (scan_frame_q)
               lfail_q <= ~eng_word[LINK_BIT];
         end
         if (start_rd)
            nval_q <= 1'b1;
         if (eng_start) begin
            busy_q       <= 1'b1;
            rd_frame_q   <= eng_rd;
            scan_frame_q <= restart || (start_rd && reg_wdata[CMD_SCN_BIT]);
         end else if (eng_done) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (reg_sel)
         SEL_CFG: reg_rdata = cfg_q;
         SEL_CMD: reg_rdata = {14'b0, cmd_q};
         SEL_ADR: reg_rdata = {3'b0, phy_q, 3'b0, ra_q};
         SEL_WDT: reg_rdata = wdat_q;
         SEL_RDT: reg_rdata = rdat_q;
         SEL_IND: reg_rdata = {12'b0, lfail_q, nval_q, 1'b0, busy_q};
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
   import mdio_mgmt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [2:0] reg_sel,
   input logic       busy,
   input logic       nval,
   input logic       mgmt_rst,
   input logic       mdc,
   input logic       mdio_o,
   input logic       mdio_oe
);
   // R5: an accepted write start raises busy on the next edge
   a_r5_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_WDT && !busy && !mgmt_rst) |=> busy);

   // R7: the management reset quiets the engine one edge later
   a_r7_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_rst |=> (!busy && !nval && !mdc && !mdio_oe));

   // R8: a driven data bit changes only together with a falling mdc
   a_r8_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

   // R8: mdc rests low whenever no frame is in progress
   a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R3: the line is driven only during a frame
   a_r3_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_wr  (reg_wr),
   .reg_sel (reg_sel),
   .busy    (busy_q),
   .nval    (nval_q),
   .mgmt_rst(mgmt_rst),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
   localparam int DIV = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   mdio_mgmt_master #(.MDC_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY-side monitor and responder
   int          k = 0;
   int          frames = 0;
   int          abort_req = 0;
   int          abort_seen = 0;
   logic [63:0] cap = '0, oecap = '0, last_cap = '0, last_oe = '0;
   logic [15:0] phy_resp = 16'h0;
   int          cyc = 0, rise_cyc = 0, mdc_period = 0, hi_len = 0;

   always @(negedge clk) cyc++;

   always @(posedge mdc) begin
      if (abort_seen != abort_req) begin
         abort_seen = abort_req;
         k = 0;
      end
      mdc_period = cyc - rise_cyc;
      rise_cyc   = cyc;
      cap   = {cap[62:0], (mdio_oe ? mdio_o : 1'b1)};
      oecap = {oecap[62:0], mdio_oe};
      if (k == 63) begin
         last_cap = cap;
         last_oe  = oecap;
         frames++;
         k = 0;
      end else begin
         k++;
      end
   end

   always @(negedge mdc) begin
      hi_len = cyc - rise_cyc;
      if (k >= 48) mdio_i = phy_resp[63-k];
      else         mdio_i = 1'b1;
   end

   function automatic logic [63:0] exp_wr(input logic [4:0] p, input logic [4:0] r,
                                          input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
   endfunction

   function automatic logic [63:0] exp_rd(input logic [4:0] p, input logic [4:0] r);
      return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h3FFFF};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [15:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      rd(3'd5, v);
      while (v[0]) begin
         @(negedge clk);
         rd(3'd5, v);
      end
   endtask

   task automatic wait_frames(input int n);
      int target = frames + n;
      while (frames < target) @(negedge clk);
   endtask

   task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      logic [15:0] v;
      wr(3'd2, {3'b0, p, 3'b0, r});
      wr(3'd3, d);
      rd(3'd5, v);
      check("R5 busy after write start", 64'(v[0]), 64'd1);
      wait_idle();
      check("R3 write frame bits", last_cap, exp_wr(p, r, d));
      check("R3 write frame drive", last_oe, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] resp);
      logic [15:0] v;
      phy_resp = resp;
      wr(3'd2, {3'b0, p, 3'b0, r});
      wr(3'd1, 16'h0001);
      rd(3'd5, v);
      check("R5 busy and not-valid during read", 64'(v & 16'h0005), 64'h5);
      wait_idle();
      check("R4 read frame bits", last_cap, exp_rd(p, r));
      check("R4 read frame release", last_oe, 64'hFFFF_FFFF_FFFC_0000);
      rd(3'd4, v);
      check("R4 read data", 64'(v), 64'(resp));
      rd(3'd5, v);
      check("R5 not-valid cleared", 64'(v[2]), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int f;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd5, v);  check("R1 indicator after reset", 64'(v), 64'd0);
      rd(3'd4, v);  check("R1 read data after reset", 64'(v), 64'd0);
      check("R1 mdc low", 64'(mdc), 64'd0);
      check("R1 oe low", 64'(mdio_oe), 64'd0);

      // R2 address register layout
      wr(3'd2, 16'hF5EA);
      rd(3'd2, v);  check("R2 address readback", 64'(v), 64'h150A);

      // R3 / R8 directed write with extreme fields
      do_write(5'h1F, 5'h00, 16'hA5C3);
      check("R8 mdc period", 64'(mdc_period), 64'(DIV));
      check("R8 mdc high phase", 64'(hi_len), 64'(DIV / 2));
      do_write(5'h00, 5'h1F, 16'h0001);
      for (int i = 0; i < 4; i++)
         do_write(5'($urandom), 5'($urandom), 16'($urandom));

      // R4 reads, directed extremes then random
      do_read(5'h01, 5'h01, 16'h0000);
      do_read(5'h1E, 5'h11, 16'hFFFF);
      for (int i = 0; i < 4; i++)
         do_read(5'($urandom), 5'($urandom), 16'($urandom));

      // R9 starts while busy are ignored
      phy_resp = 16'h1234;
      wr(3'd2, {3'b0, 5'h0C, 3'b0, 5'h03});
      wr(3'd3, 16'h6B2D);
      repeat (500) @(negedge clk);
      wr(3'd3, 16'h0F0F);
      wr(3'd1, 16'h0001);
      wait_idle();
      check("R9 frame unaltered", last_cap, exp_wr(5'h0C, 5'h03, 16'h6B2D));
      f = frames;
      repeat (3 * DIV) @(negedge clk);
      rd(3'd5, v);
      check("R9 no later frame", 64'(frames), 64'(f));
      check("R9 indicator idle", 64'(v), 64'd0);
      wr(3'd1, 16'h0000);

      // R6 scan with link down then up
      phy_resp = 16'h7809;
      wr(3'd2, {3'b0, 5'h01, 3'b0, 5'h01});
      wr(3'd1, 16'h0002);
      wait_frames(2);
      repeat (DIV) @(negedge clk);
      rd(3'd5, v);
      check("R6 link-fail set", 64'(v[3]), 64'd1);
      check("R6 busy held in scan", 64'(v[0]), 64'd1);
      rd(3'd4, v);  check("R6 scan data", 64'(v), 64'h7809);
      phy_resp = 16'h782D;
      wait_frames(2);
      repeat (DIV) @(negedge clk);
      rd(3'd5, v);  check("R6 link-fail cleared", 64'(v[3]), 64'd0);
      rd(3'd4, v);  check("R6 scan data update", 64'(v), 64'h782D);
      wr(3'd1, 16'h0000);
      wait_idle();
      f = frames;
      repeat (3 * DIV) @(negedge clk);
      check("R6 scan stops", 64'(frames), 64'(f));

      // R7 management reset aborts and blocks
      wr(3'd2, {3'b0, 5'h05, 3'b0, 5'h06});
      wr(3'd3, 16'hBEEF);
      repeat (300) @(negedge clk);
      wr(3'd0, 16'h8000);
      @(negedge clk);
      rd(3'd5, v);
      check("R7 indicator cleared", 64'(v), 64'd0);
      check("R7 oe low", 64'(mdio_oe), 64'd0);
      repeat (100) @(negedge clk);
      check("R7 mdc held low", 64'(mdc), 64'd0);
      wr(3'd3, 16'h1111);
      rd(3'd5, v);
      check("R7 start ignored", 64'(v[0]), 64'd0);
      wr(3'd0, 16'h0000);
      abort_req++;
      do_read(5'h07, 5'h02, 16'hC0DE);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule